// File: doc/BRIEF.md
# Phase Lock Alarm Controller

This block keeps one sticky phase-lock alarm flag per reference input, together with a small set of configuration fields that a clock-synchronization subsystem reads. A lock detector outside the block sends a one-cycle pulse on an input's raise line. The flag is then set. A mode bit picks how the flag goes away. In manual mode, software must write a one to that flag's bit. In automatic mode, a per-input timer clears the flag after a programmed number of seconds has passed since it was raised. The second count comes from an external one-second tick.

The same configuration holds the rules for an external frame-sync input. That input can be blocked, always allowed to align the frame-sync outputs, or allowed only while one chosen reference is selected. The block also decodes the nominal rate of that input and passes on the reference-switching policy and the network type. The network type is sampled from a strap pin during reset. A read-only bit shows a second strap pin directly. Software reaches the registers through a simple port: a single-cycle write strobe, and read data that follows the address combinationally.

Top module: `plc_alarm_ctrl`

## Requirements
- R1: After reset every alarm flag is 0, automatic clearing is selected, frame sync is disabled, the rate code is 0, revertive is 0, the timeout register reads 0x04, and the network bit holds the value that `strap_sonet` had during reset. The mode register therefore reads 0xC1 with both straps at 1.
- R2: A one on `raise[i]` sets `alarm[i]` at the next clock edge. If a raise and a clearing event for the same flag arrive in the same cycle, the raise wins.
- R3: With mode bit 0 at 0 (manual), a flag clears only when a one is written to its bit at address 2. Zero bits in that write and one-second ticks leave the flag unchanged.
- R4: With mode bit 0 at 1 (automatic), a flag clears at the L-th tick after its raise. L = timeout[5:0] × factor, where timeout[7:6] values 00, 01, 10 and 11 give factors 1, 2, 4 and 8. The values are taken from address 1 when the raise occurs.
- R5: In automatic mode, when L is 0 the flag clears at the first tick after the raise.
- R6: A raise on a flag that is already set restarts that flag's count from its full value.
- R7: In automatic mode, writing a one to a flag's bit at address 2 clears it at the next edge and stops its timer.
- R8: `sync_enable` depends on mode bits 1 (auto) and 2 (force). If auto is 1, it is 1 exactly while `sel_ref` equals 5, and force is ignored. Otherwise it equals force.
- R9: `sync_rate` decodes mode bits 4:3. The values 00 and 01 give 0 (8 kHz), 10 gives 1 (4 kHz) and 11 gives 2 (2 kHz).
- R10: Mode bit 5 drives `revertive` and mode bit 6 drives `sonet_mode`. Mode bit 7 always reads `strap_master`, and writes to it are ignored.
- R11: `rdata` shows the register at `addr` in the same cycle. Address 0 is mode, 1 is timeout, 2 is the alarm flags, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sonet | input | 1 | Network-type strap, sampled while in reset |
| strap_master | input | 1 | Master/slave strap, shown live in mode bit 7 |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| raise | input | 8 | Per-input alarm raise pulses |
| sel_ref | input | 3 | Index of the selected reference |
| tick_1s | input | 1 | One-second tick pulse |
| alarm | output | 8 | Alarm flags |
| sync_enable | output | 1 | External frame sync allowed |
| sync_rate | output | 2 | Decoded frame sync rate code |
| revertive | output | 1 | Revertive switching selected |
| sonet_mode | output | 1 | Network type, 1 = SONET |

## Verification
Writes, raises and ticks all act at the first clock edge after they are driven, so the flags and register contents change one cycle later. `sync_enable`, `sync_rate` and `rdata` are combinational from that registered state and from the live `sel_ref`, `addr` and `strap_master` inputs. The bench drives its inputs just after a rising edge. Its reference model updates on that same edge from the previous inputs, and every output is compared at the falling edge that follows. Directed checks are placed after the edge that should take effect, counting each tick pulse. The 5th and 6th ticks of a 6-second window, for example, are checked separately.

// File: rtl/plc_pkg.sv
package plc_pkg;

    localparam int ADDR_MODE = 0;
    localparam int ADDR_TMO  = 1;
    localparam int ADDR_ALM  = 2;

    typedef struct packed {
        logic       sonet;
        logic       revertive;
        logic [1:0] rate;
        logic       sync_force;
        logic       sync_auto;
        logic       clr_auto;
    } mode_t;

    typedef enum logic [1:0] {
        RATE_8K = 2'd0,
        RATE_4K = 2'd1,
        RATE_2K = 2'd2
    } rate_code_e;

endpackage

// File: rtl/plc_cfg_regs.sv
module plc_cfg_regs
    import plc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int TMO_W   = 6,
    parameter int MUL_W   = 2,
    parameter int TMO_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sonet,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode,
    output logic [TMO_W-1:0]  tmo_val,
    output logic [MUL_W-1:0]  tmo_mul
);

    typedef struct packed {
        mode_t            mode;
        logic [TMO_W-1:0] tmo;
        logic [MUL_W-1:0] mul;
    } cfg_state_t;

    cfg_state_t st_d, st_q, st_rst;

    always_comb begin
        st_rst                 = '0;
        st_rst.mode.clr_auto   = 1'b1;
        st_rst.mode.sonet      = strap_sonet;
        st_rst.tmo             = TMO_W'(TMO_RST);

        st_d = st_q;
        if (wr_en && addr == ADDR_W'(ADDR_MODE)) begin
            st_d.mode.clr_auto   = wdata[0];
            st_d.mode.sync_auto  = wdata[1];
            st_d.mode.sync_force = wdata[2];
            st_d.mode.rate       = wdata[4:3];
            st_d.mode.revertive  = wdata[5];
            st_d.mode.sonet      = wdata[6];
        end
        if (wr_en && addr == ADDR_W'(ADDR_TMO)) begin
            st_d.tmo = wdata[TMO_W-1:0];
            st_d.mul = wdata[TMO_W+MUL_W-1:TMO_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign mode    = st_q.mode;
    assign tmo_val = st_q.tmo;
    assign tmo_mul = st_q.mul;

    // R10: a mode write lands next cycle
    a_r10_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_MODE)) |=>
        (mode.revertive == $past(wdata[5]) && mode.sonet == $past(wdata[6])));

    // R4: timeout write lands next cycle
    a_r4_tmo_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_TMO)) |=>
        (tmo_val == $past(wdata[TMO_W-1:0])));

endmodule

// File: rtl/plc_alarm_chan.sv
module plc_alarm_chan #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             wclr,
    input  logic             tick,
    input  logic             auto_clr,
    input  logic [CNT_W-1:0] load_val,
    output logic             alarm
);

    typedef struct packed {
        logic             alarm;
        logic [CNT_W-1:0] rem;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (raise) begin
            ch_d.alarm = 1'b1;
            ch_d.rem   = load_val;
        end else if (wclr) begin
            ch_d.alarm = 1'b0;
            ch_d.rem   = '0;
        end else if (auto_clr && tick && ch_q.alarm) begin
            if (ch_q.rem <= CNT_W'(1)) begin
                ch_d.alarm = 1'b0;
                ch_d.rem   = '0;
            end else begin
                ch_d.rem = ch_q.rem - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign alarm = ch_q.alarm;

    a_r2_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> alarm);

    a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(raise));

    // R3 / R4 / R7: a flag only drops after a write-clear or an automatic tick
    a_r3_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> $past(wclr || (auto_clr && tick)));

    a_r3_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !auto_clr && !wclr) |=> alarm);

endmodule

// File: rtl/plc_sync_ctl.sv
module plc_sync_ctl
    import plc_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int SYNC_IDX = 5
) (
    input  logic [SEL_W-1:0] sel_ref,
    input  logic             sync_auto,
    input  logic             sync_force,
    input  logic [1:0]       rate_field,
    output logic             sync_enable,
    output logic [1:0]       sync_rate
);

    rate_code_e code;

    always_comb begin
        if (sync_auto) sync_enable = (sel_ref == SEL_W'(SYNC_IDX));
        else           sync_enable = sync_force;

        unique case (rate_field)
            2'b10:   code = RATE_4K;
            2'b11:   code = RATE_2K;
            default: code = RATE_8K;
        endcase
        sync_rate = code;
    end

endmodule

// File: rtl/plc_alarm_ctrl.sv
module plc_alarm_ctrl
    import plc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2,
    parameter int NUM_IN   = 8,
    parameter int SEL_W    = 3,
    parameter int TMO_W    = 6,
    parameter int MUL_W    = 2,
    parameter int TMO_RST  = 4,
    parameter int SYNC_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_sonet,
    input  logic              strap_master,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_IN-1:0] raise,
    input  logic [SEL_W-1:0]  sel_ref,
    input  logic              tick_1s,
    output logic [NUM_IN-1:0] alarm,
    output logic              sync_enable,
    output logic [1:0]        sync_rate,
    output logic              revertive,
    output logic              sonet_mode
);

    localparam int CNT_W = TMO_W + (1 << MUL_W) - 1;

    mode_t             mode;
    logic [TMO_W-1:0]  tmo_val;
    logic [MUL_W-1:0]  tmo_mul;
    logic [CNT_W-1:0]  load_val;
    logic              alm_wr;

    plc_cfg_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .TMO_W  (TMO_W),
        .MUL_W  (MUL_W),
        .TMO_RST(TMO_RST)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_sonet(strap_sonet),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .mode       (mode),
        .tmo_val    (tmo_val),
        .tmo_mul    (tmo_mul)
    );

    assign load_val = CNT_W'(tmo_val) << tmo_mul;
    assign alm_wr   = wr_en && (addr == ADDR_W'(ADDR_ALM));

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chan
        plc_alarm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise   (raise[gi]),
            .wclr    (alm_wr && wdata[gi]),
            .tick    (tick_1s),
            .auto_clr(mode.clr_auto),
            .load_val(load_val),
            .alarm   (alarm[gi])
        );
    end

    plc_sync_ctl #(
        .SEL_W   (SEL_W),
        .SYNC_IDX(SYNC_IDX)
    ) u_sync (
        .sel_ref    (sel_ref),
        .sync_auto  (mode.sync_auto),
        .sync_force (mode.sync_force),
        .rate_field (mode.rate),
        .sync_enable(sync_enable),
        .sync_rate  (sync_rate)
    );

    assign revertive  = mode.revertive;
    assign sonet_mode = mode.sonet;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_MODE): rdata[7:0] = {strap_master, mode.sonet, mode.revertive,
                                              mode.rate, mode.sync_force,
                                              mode.sync_auto, mode.clr_auto};
            ADDR_W'(ADDR_TMO):  rdata[TMO_W+MUL_W-1:0] = {tmo_mul, tmo_val};
            ADDR_W'(ADDR_ALM):  rdata[NUM_IN-1:0] = alarm;
            default:            rdata = '0;
        endcase
    end

    // R7: write-one clear without a raise drops the flag next cycle
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_wr && wdata[0] && !raise[0]) |=> !alarm[0]);

    // R10: strap mirror is live on the read port
    a_r10_strap_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(ADDR_MODE)) |-> (rdata[7] == strap_master));

endmodule

// File: tb/sim_plc_alarm_ctrl.sv
module sim_plc_alarm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_sonet = 1'b1;
    logic       strap_master = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [7:0] raise = 8'd0;
    logic [2:0] sel_ref = 3'd0;
    logic       tick_1s = 1'b0;
    logic [7:0] alarm;
    logic       sync_enable;
    logic [1:0] sync_rate;
    logic       revertive;
    logic       sonet_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plc_alarm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .strap_sonet(strap_sonet), .strap_master(strap_master),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .raise(raise),
        .sel_ref(sel_ref), .tick_1s(tick_1s), .alarm(alarm), .sync_enable(sync_enable),
        .sync_rate(sync_rate), .revertive(revertive), .sonet_mode(sonet_mode)
    );

    // behavioural reference model
    bit m_alarm [N];
    int m_rem   [N];
    bit m_clr_auto, m_sauto, m_sforce, m_rev, m_sonet;
    int m_rate, m_tmo, m_mul;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_alarm[i]) begin m_alarm[i] = 0; m_rem[i] = 0; end
            m_clr_auto = 1; m_sauto = 0; m_sforce = 0; m_rev = 0;
            m_sonet = strap_sonet; m_rate = 0; m_tmo = 4; m_mul = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (raise[i]) begin
                    m_alarm[i] = 1; m_rem[i] = m_tmo * (1 << m_mul);
                end else if (wr_en && addr == 2 && wdata[i]) begin
                    m_alarm[i] = 0; m_rem[i] = 0;
                end else if (m_clr_auto && tick_1s && m_alarm[i]) begin
                    if (m_rem[i] <= 1) begin m_alarm[i] = 0; m_rem[i] = 0; end
                    else m_rem[i] = m_rem[i] - 1;
                end
            end
            if (wr_en && addr == 0) begin
                m_clr_auto = wdata[0]; m_sauto = wdata[1]; m_sforce = wdata[2];
                m_rate = wdata[4:3]; m_rev = wdata[5]; m_sonet = wdata[6];
            end
            if (wr_en && addr == 1) begin
                m_tmo = wdata[5:0]; m_mul = wdata[7:6];
            end
        end
    end

    function automatic logic [7:0] m_alarm_vec();
        logic [7:0] v;
        for (int i = 0; i < N; i++) v[i] = m_alarm[i];
        return v;
    endfunction

    function automatic logic [7:0] m_rdata();
        case (addr)
            2'd0: return {strap_master, m_sonet, m_rev, 2'(m_rate), m_sforce, m_sauto, m_clr_auto};
            2'd1: return {2'(m_mul), 6'(m_tmo)};
            2'd2: return m_alarm_vec();
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 model alarm", alarm, m_alarm_vec());
            chk("R8 model sync_enable", sync_enable, m_sauto ? (sel_ref == 3'd5) : m_sforce);
            chk("R9 model sync_rate", sync_rate, (m_rate == 3) ? 2 : (m_rate == 2) ? 1 : 0);
            chk("R10 model revertive/sonet", {revertive, sonet_mode}, {m_rev, m_sonet});
            chk("R11 model rdata", rdata, m_rdata());
        end
    end

    task automatic step();
        @(posedge clk); #1;
        wr_en = 0; raise = 8'd0; tick_1s = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        step();
    endtask

    task automatic rise(input logic [7:0] m);
        @(posedge clk); #1;
        raise = m;
        step();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            tick_1s = 1;
            step();
        end
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        strap_sonet = 0;
        look();
        chk("R1 alarms after reset", alarm, 0);
        addr = 0; #1;
        chk("R1 mode register reset", rdata, 8'hC1);
        chk("R1 sonet from strap", sonet_mode, 1);
        chk("R1 sync disabled", sync_enable, 0);
        addr = 1; #1;
        chk("R1 timeout register reset", rdata, 8'h04);

        // R2 raise
        rise(8'h01); look();
        chk("R2 raise sets flag", alarm[0], 1);
        ticks(4); look();
        chk("R4 default 4 s clear", alarm[0], 0);

        // R3 manual mode
        wr(0, 8'h00);
        rise(8'h06);
        ticks(5); look();
        chk("R3 ticks ignored in manual", alarm[2:1], 2'b11);
        wr(2, 8'hF9); look();
        chk("R3 zero bits ignored", alarm[2:1], 2'b11);
        wr(2, 8'h02); look();
        chk("R3 write one clears bit1", alarm[2:1], 2'b10);
        wr(2, 8'h04); look();
        chk("R3 write one clears bit2", alarm[2], 0);

        // R2 priority of raise over clear
        @(posedge clk); #1;
        raise = 8'h08; wr_en = 1; addr = 2; wdata = 8'h08;
        step(); look();
        chk("R2 raise beats clear", alarm[3], 1);
        wr(2, 8'h08);

        // R4 automatic windows
        wr(0, 8'h01);
        wr(1, 8'h43);
        rise(8'h10);
        ticks(5); look();
        chk("R4 L=6 still set after 5", alarm[4], 1);
        ticks(1); look();
        chk("R4 L=6 clear after 6", alarm[4], 0);
        wr(1, 8'hC1);
        rise(8'h20);
        ticks(7); look();
        chk("R4 L=8 still set after 7", alarm[5], 1);
        ticks(1); look();
        chk("R4 L=8 clear after 8", alarm[5], 0);

        // R5 zero timeout
        wr(1, 8'h00);
        rise(8'h40); look();
        chk("R5 set before tick", alarm[6], 1);
        ticks(1); look();
        chk("R5 zero timeout first tick", alarm[6], 0);

        // R6 restart
        wr(1, 8'h04);
        rise(8'h80);
        ticks(3);
        rise(8'h80);
        ticks(3); look();
        chk("R6 restarted timer holds", alarm[7], 1);
        ticks(1); look();
        chk("R6 restarted timer expires", alarm[7], 0);

        // R7 immediate clear in automatic mode
        rise(8'h01);
        wr(2, 8'h01); look();
        chk("R7 w1c in auto mode", alarm[0], 0);
        ticks(5); look();
        chk("R7 timer stopped", alarm[0], 0);

        // R8 sync decision
        wr(0, 8'h05);
        sel_ref = 3'd2; look();
        chk("R8 forced enable", sync_enable, 1);
        wr(0, 8'h07);
        sel_ref = 3'd4; look();
        chk("R8 auto ignores force", sync_enable, 0);
        sel_ref = 3'd5; look();
        chk("R8 auto on input 5", sync_enable, 1);
        wr(0, 8'h01); look();
        chk("R8 both off", sync_enable, 0);
        for (int s = 0; s < 8; s++) begin sel_ref = 3'(s); look(); end

        // R9 rate decode
        wr(0, 8'h09); look();
        chk("R9 rate 01 -> 8k", sync_rate, 0);
        wr(0, 8'h11); look();
        chk("R9 rate 10 -> 4k", sync_rate, 1);
        wr(0, 8'h19); look();
        chk("R9 rate 11 -> 2k", sync_rate, 2);

        // R10 policy bits and read-only strap mirror
        strap_master = 0;
        wr(0, 8'hE1);
        addr = 0; look();
        chk("R10 revertive", revertive, 1);
        chk("R10 sonet", sonet_mode, 1);
        chk("R10 strap bit read-only", rdata[7], 0);
        strap_master = 1; #1;
        chk("R10 strap bit live", rdata[7], 1);

        // R11 unused address
        addr = 3; #1;
        chk("R11 address 3 reads 0", rdata, 0);
        look();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule